// File: doc/BRIEF.md
# Clause-22 Management Register Slave

This block is the management slave for a single PHY port. A station manager sends serial frames on a management clock and data line pair. The block checks each frame's address against its own PHY address, and it serves reads and writes of the control register (address 0) and the advertisement register (address 4). All other register addresses read as zero. From the stored register state it drives the control outputs that the rest of the port uses: soft reset, loopback, power-down, isolate, negotiation enable and restart, speed and duplex. It takes the negotiated speed and duplex back as inputs.

Several inputs are straps that are captured while the system reset is held low. These are the upper two PHY address bits, the fibre-medium select, the fibre duplex default and the two pause defaults. These latched values set the register defaults, both after the system reset and after a soft reset. The management clock and data line are oversampled by the system clock. After reset is released, the block ignores every frame until a programmable hold-off count has expired.

Top module: `mii_mgmt_regs`

## Requirements
- R1: A frame is at least 32 ones, then start bits 0 and 1, a 2-bit opcode (10 read, 01 write), a 5-bit PHY address and a 5-bit register address, all MSB first. On a read, the line is released during the first turnaround bit, driven 0 during the second, and then carries 16 data bits MSB first. It is released again after the last data bit.
- R2: A frame is served only when its PHY address equals {latched strap_phy_hi, PHY_LOW}. Any other frame is ignored: mdio_oe stays 0 and no register changes.
- R3: Frames whose header completes before HOLDOFF_CYCLES system clocks have passed since reset release are ignored, with the line left released.
- R4: Writing 1 to control bit 15 pulses ctl_reset for one cycle and restores every register to its strap default. The bit always reads 0.
- R5: Writing 1 to control bit 9 pulses ctl_an_restart for one cycle. The bit always reads 0.
- R6: Control bit 13 (speed, 1 = 100 Mb/s) reads 1 in fibre mode. Otherwise it reads an_speed while bit 12 is set, and the stored value otherwise. The stored value is written only by a control write whose bit 12 is 0.
- R7: Control bit 8 (duplex, 1 = full) reads an_duplex while bit 12 is set, and the stored value otherwise. The stored value defaults to strap_fx_duplex in fibre mode and to 1 otherwise.
- R8: Control bit 12 (negotiation enable) defaults to 1 on a twisted-pair port and to 0 on a fibre port. Control bits 7..0 always read 0.
- R9: While control bit 11 (power-down) is set, ctl_an_enable, ctl_an_restart and ctl_loopback are held at 0, and management reads and writes still work.
- R10: ctl_loopback follows control bit 14 only while the effective speed is 10 Mb/s.
- R11: The advertisement register reads {5'b0, pause, 1'b0, abilities[3:0], 5'b00001}. The pause bit (bit 10) defaults to strap_fx_pause on a fibre port and to strap_tp_pause otherwise. The abilities (bits 8..5) default to 1111, and both fields are writable.
- R12: Register addresses other than 0 and 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| mdc | input | 1 | Management clock, oversampled |
| mdio_in | input | 1 | Management data line as seen at the pin |
| mdio_out | output | 1 | Data driven onto the line |
| mdio_oe | output | 1 | Drive enable for the line |
| strap_phy_hi | input | 2 | Upper PHY address bits strap |
| strap_fx_mode | input | 1 | Port is on fibre medium |
| strap_fx_duplex | input | 1 | Fibre duplex default |
| strap_tp_pause | input | 1 | Twisted-pair pause default |
| strap_fx_pause | input | 1 | Fibre pause default |
| an_speed | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| an_duplex | input | 1 | Negotiated duplex, 1 = full |
| ctl_reset | output | 1 | One-cycle soft reset pulse |
| ctl_loopback | output | 1 | Loopback enable, active only at 10 Mb/s |
| ctl_power_down | output | 1 | Power-down request |
| ctl_isolate | output | 1 | Isolate from the MAC side |
| ctl_an_enable | output | 1 | Negotiation enable |
| ctl_an_restart | output | 1 | One-cycle negotiation restart pulse |
| ctl_speed | output | 1 | Effective speed, 1 = 100 Mb/s |
| ctl_duplex | output | 1 | Effective duplex, 1 = full |

## Verification
The hardest state to reach is the fibre-mode defaults. The straps are only captured while reset is held, so the stimulus applies a second system reset with the fibre straps and a different upper address. It then waits out the hold-off again and repeats the default reads at the new address, also confirming that the old address falls silent. The hold-off window is reached by starting a read immediately after reset, with a bench hold-off longer than the header time. A sweep over all 32 PHY addresses shows that only the single matching address ever enables the line driver.

// File: rtl/mgmt_pkg.sv
// Shared constants and types for the management register slave.
// Assumes clause-22 framing with 5-bit PHY and register addresses.
package mgmt_pkg;
    localparam int PRE_MIN  = 32;
    localparam int HDR_BITS = 13;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [4:0] REG_CTL = 5'd0;
    localparam logic [4:0] REG_ADV = 5'd4;

    typedef enum logic [2:0] {
        F_PRE, F_HDR, F_TA_RD, F_RD, F_TA_WR, F_WR
    } frame_st_e;
endpackage

// File: rtl/mgmt_holdoff.sv
// Counts system clocks after reset release and flags when frames may be served.
// Assumes CYCLES >= 1; the count saturates and never restarts without rst_n.
module mgmt_holdoff #(
    parameter int CYCLES = 140000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    // Saturating post-reset counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (cnt != CW'(CYCLES))      cnt <= cnt + 1'b1;
    end

    assign done = (cnt == CW'(CYCLES));
endmodule

// File: rtl/mdio_frame.sv
// Serial frame engine: finds preamble, decodes the header, shifts read data
// out and write data in. One step per sampled management clock rising edge.
// Assumes rd_data is a combinational lookup of lookup_addr.
module mdio_frame
    import mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_stb,
    input  logic        bit_val,
    input  logic [4:0]  phy_addr,
    input  logic        accept,
    output logic [4:0]  lookup_addr,
    input  logic [15:0] rd_data,
    output logic        wr_stb,
    output logic [4:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic        mdio_out,
    output logic        mdio_oe
);
    localparam int OW = $clog2(PRE_MIN + 1);

    frame_st_e            st;
    logic [OW-1:0]        ones;
    logic [HDR_BITS-2:0]  hdr;
    logic [HDR_BITS-1:0]  full;
    logic [4:0]           cnt;
    logic [15:0]          shreg;
    logic                 hit;

    assign full        = {hdr, bit_val};
    assign lookup_addr = full[4:0];
    assign hit = accept && full[12] && full[9:5] == phy_addr &&
                 (full[11:10] == OP_RD || full[11:10] == OP_WR);
    assign wr_data = shreg;

    // Frame sequencer driven by sampled management clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= F_PRE; ones <= '0; hdr <= '0; cnt <= '0; shreg <= '0;
            wr_addr <= '0; wr_stb <= 1'b0; mdio_out <= 1'b0; mdio_oe <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (bit_stb) begin
                case (st)
                    F_PRE: begin
                        if (bit_val) begin
                            if (ones != OW'(PRE_MIN)) ones <= ones + 1'b1;
                        end else begin
                            if (ones == OW'(PRE_MIN)) begin
                                st <= F_HDR; cnt <= '0;
                            end
                            ones <= '0;
                        end
                    end
                    F_HDR: begin
                        hdr <= full[HDR_BITS-2:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == 5'(HDR_BITS - 1)) begin
                            st <= F_PRE;
                            if (hit) begin
                                wr_addr <= full[4:0];
                                cnt     <= '0;
                                if (full[11:10] == OP_RD) begin
                                    st <= F_TA_RD; shreg <= rd_data;
                                end else begin
                                    st <= F_TA_WR;
                                end
                            end
                        end
                    end
                    F_TA_RD: begin
                        mdio_oe <= 1'b1; mdio_out <= 1'b0; st <= F_RD; cnt <= '0;
                    end
                    F_RD: begin
                        if (cnt == 5'd16) begin
                            mdio_oe <= 1'b0; mdio_out <= 1'b0; st <= F_PRE;
                        end else begin
                            mdio_out <= shreg[15];
                            shreg    <= {shreg[14:0], 1'b0};
                            cnt      <= cnt + 1'b1;
                        end
                    end
                    F_TA_WR: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == 5'd1) begin st <= F_WR; cnt <= '0; end
                    end
                    F_WR: begin
                        shreg <= {shreg[14:0], bit_val};
                        cnt   <= cnt + 1'b1;
                        if (cnt == 5'd15) begin wr_stb <= 1'b1; st <= F_PRE; end
                    end
                    default: st <= F_PRE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mgmt_regfile.sv
// Control and advertisement registers with strap defaults, self-clearing
// bits and negotiation/fibre overrides. Straps are captured while rst_n is low.
module mgmt_regfile
    import mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  strap_phy_hi,
    input  logic        strap_fx_mode,
    input  logic        strap_fx_duplex,
    input  logic        strap_tp_pause,
    input  logic        strap_fx_pause,
    input  logic        an_speed,
    input  logic        an_duplex,
    input  logic [4:0]  rd_addr,
    output logic [15:0] rd_data,
    input  logic        wr_stb,
    input  logic [4:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic [1:0]  phy_hi,
    output logic        fx_mode,
    output logic        ctl_reset,
    output logic        ctl_loopback,
    output logic        ctl_power_down,
    output logic        ctl_isolate,
    output logic        ctl_an_enable,
    output logic        ctl_an_restart,
    output logic        ctl_speed,
    output logic        ctl_duplex
);
    logic       dup_def, pause_def;
    logic       loop_q, an_en_q, pdn_q, iso_q, spd_q, dup_q, pause_q;
    logic [3:0] abil_q;
    logic       rst_p, rstrt_p;
    logic       spd_eff, dup_eff;

    // Strap capture, register writes and self-clearing pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_hi    <= strap_phy_hi;
            fx_mode   <= strap_fx_mode;
            dup_def   <= strap_fx_mode ? strap_fx_duplex : 1'b1;
            pause_def <= strap_fx_mode ? strap_fx_pause : strap_tp_pause;
            loop_q <= 1'b0; an_en_q <= ~strap_fx_mode; pdn_q <= 1'b0; iso_q <= 1'b0;
            spd_q  <= 1'b1; dup_q <= strap_fx_mode ? strap_fx_duplex : 1'b1;
            pause_q <= strap_fx_mode ? strap_fx_pause : strap_tp_pause;
            abil_q <= 4'hF; rst_p <= 1'b0; rstrt_p <= 1'b0;
        end else begin
            rst_p   <= 1'b0;
            rstrt_p <= 1'b0;
            if (wr_stb && wr_addr == REG_CTL) begin
                if (wr_data[15]) begin
                    rst_p  <= 1'b1;
                    loop_q <= 1'b0; an_en_q <= ~fx_mode; pdn_q <= 1'b0; iso_q <= 1'b0;
                    spd_q  <= 1'b1; dup_q <= dup_def;
                    pause_q <= pause_def; abil_q <= 4'hF;
                end else begin
                    loop_q  <= wr_data[14];
                    an_en_q <= wr_data[12];
                    pdn_q   <= wr_data[11];
                    iso_q   <= wr_data[10];
                    rstrt_p <= wr_data[9];
                    if (!wr_data[12]) begin
                        spd_q <= wr_data[13];
                        dup_q <= wr_data[8];
                    end
                end
            end
            if (wr_stb && wr_addr == REG_ADV) begin
                pause_q <= wr_data[10];
                abil_q  <= wr_data[8:5];
            end
        end
    end

    // Effective speed/duplex after negotiation and fibre overrides.
    always_comb begin
        spd_eff = fx_mode | (an_en_q ? an_speed : spd_q);
        dup_eff = an_en_q ? an_duplex : dup_q;
    end

    // Read multiplexer; self-clearing bits read as zero.
    always_comb begin
        case (rd_addr)
            REG_CTL: rd_data = {1'b0, loop_q, spd_eff, an_en_q, pdn_q, iso_q,
                                1'b0, dup_eff, 8'h00};
            REG_ADV: rd_data = {5'b0, pause_q, 1'b0, abil_q, 5'b00001};
            default: rd_data = 16'h0000;
        endcase
    end

    assign ctl_reset      = rst_p;
    assign ctl_power_down = pdn_q;
    assign ctl_isolate    = iso_q;
    assign ctl_an_enable  = an_en_q & ~pdn_q;
    assign ctl_an_restart = rstrt_p & ~pdn_q;
    assign ctl_loopback   = loop_q & ~spd_eff & ~pdn_q;
    assign ctl_speed      = spd_eff;
    assign ctl_duplex     = dup_eff;
endmodule

// File: rtl/mii_mgmt_regs.sv
// Top: oversamples the management clock/data, gates service by the hold-off
// and address straps, and exposes the control outputs of one PHY port.
// Assumes mdc is slower than a quarter of clk.
module mii_mgmt_regs #(
    parameter logic [2:0] PHY_LOW        = 3'b000,
    parameter int         HOLDOFF_CYCLES = 140000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mdc,
    input  logic       mdio_in,
    output logic       mdio_out,
    output logic       mdio_oe,
    input  logic [1:0] strap_phy_hi,
    input  logic       strap_fx_mode,
    input  logic       strap_fx_duplex,
    input  logic       strap_tp_pause,
    input  logic       strap_fx_pause,
    input  logic       an_speed,
    input  logic       an_duplex,
    output logic       ctl_reset,
    output logic       ctl_loopback,
    output logic       ctl_power_down,
    output logic       ctl_isolate,
    output logic       ctl_an_enable,
    output logic       ctl_an_restart,
    output logic       ctl_speed,
    output logic       ctl_duplex
);
    logic [2:0]  mdc_sr;
    logic [1:0]  dat_sr;
    logic        bit_stb, hold_done, fx_latched, wr_stb;
    logic [1:0]  phy_hi;
    logic [4:0]  lookup_addr, wr_addr;
    logic [15:0] rd_data, wr_data;

    // Synchronise the management clock and data into the system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_sr <= '0; dat_sr <= '0;
        end else begin
            mdc_sr <= {mdc_sr[1:0], mdc};
            dat_sr <= {dat_sr[0], mdio_in};
        end
    end

    assign bit_stb = mdc_sr[1] & ~mdc_sr[2];

    mgmt_holdoff #(.CYCLES(HOLDOFF_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .done(hold_done)
    );

    mdio_frame u_frame (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(dat_sr[1]),
        .phy_addr({phy_hi, PHY_LOW}), .accept(hold_done),
        .lookup_addr(lookup_addr), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    mgmt_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .strap_phy_hi(strap_phy_hi), .strap_fx_mode(strap_fx_mode),
        .strap_fx_duplex(strap_fx_duplex), .strap_tp_pause(strap_tp_pause),
        .strap_fx_pause(strap_fx_pause), .an_speed(an_speed), .an_duplex(an_duplex),
        .rd_addr(lookup_addr), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .phy_hi(phy_hi), .fx_mode(fx_latched),
        .ctl_reset(ctl_reset), .ctl_loopback(ctl_loopback),
        .ctl_power_down(ctl_power_down), .ctl_isolate(ctl_isolate),
        .ctl_an_enable(ctl_an_enable), .ctl_an_restart(ctl_an_restart),
        .ctl_speed(ctl_speed), .ctl_duplex(ctl_duplex)
    );
endmodule

// File: rtl/mii_mgmt_regs_chk.sv
// Property checker for the management slave, bound into every instance.
module mii_mgmt_regs_chk (
    input logic clk,
    input logic rst_n,
    input logic mdio_oe,
    input logic mdio_out,
    input logic hold_done,
    input logic fx_latched,
    input logic an_speed,
    input logic ctl_reset,
    input logic ctl_loopback,
    input logic ctl_power_down,
    input logic ctl_an_enable,
    input logic ctl_an_restart,
    input logic ctl_speed
);
    // R1: the first driven turnaround bit is a zero.
    assert_ta_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);
    // R3: no driving of the line while the hold-off runs.
    assert_holdoff_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_done |-> !mdio_oe);
    // R4: soft reset is a single-cycle pulse.
    assert_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> !ctl_reset);
    // R5: restart is a single-cycle pulse.
    assert_restart_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_an_restart |=> !ctl_an_restart);
    // R6: fibre forces 100 Mb/s; negotiation result drives speed otherwise.
    assert_fx_speed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fx_latched |-> ctl_speed);
    assert_an_speed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_an_enable && !fx_latched) |-> ctl_speed == an_speed);
    // R9: power-down silences the functional controls.
    assert_pdn_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_power_down |-> !ctl_an_enable && !ctl_an_restart && !ctl_loopback);
    // R10: loopback only at 10 Mb/s.
    assert_loop_10m_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_loopback |-> !ctl_speed);
endmodule

bind mii_mgmt_regs mii_mgmt_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_out(mdio_out),
    .hold_done(hold_done), .fx_latched(fx_latched), .an_speed(an_speed),
    .ctl_reset(ctl_reset), .ctl_loopback(ctl_loopback),
    .ctl_power_down(ctl_power_down), .ctl_an_enable(ctl_an_enable),
    .ctl_an_restart(ctl_an_restart), .ctl_speed(ctl_speed)
);

// File: tb/sim_mii_mgmt_regs.sv
`timescale 1ns/1ps
// Bench: drives complete management frames bit by bit and checks read data,
// turnaround timing, control outputs and address/hold-off filtering.
module sim_mii_mgmt_regs;
    localparam logic [2:0] PHY_LOW = 3'b101;
    localparam int HOLD = 2000;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, drv = 1'b1;
    logic mdio_out, mdio_oe, mdio_line;
    logic [1:0] s_phy = 2'b01;
    logic s_fx = 1'b0, s_fxdup = 1'b1, s_tpp = 1'b1, s_fxp = 1'b0;
    logic an_spd = 1'b1, an_dup = 1'b0;
    logic c_rst, c_loop, c_pdn, c_iso, c_an, c_rstrt, c_spd, c_dup;
    int   n_tests = 0, n_fail = 0, cyc = 0, rst_pulses = 0, rstrt_pulses = 0;

    always #2.5 clk = ~clk;
    assign mdio_line = mdio_oe ? mdio_out : drv;

    mii_mgmt_regs #(.PHY_LOW(PHY_LOW), .HOLDOFF_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_line),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .strap_phy_hi(s_phy), .strap_fx_mode(s_fx), .strap_fx_duplex(s_fxdup),
        .strap_tp_pause(s_tpp), .strap_fx_pause(s_fxp),
        .an_speed(an_spd), .an_duplex(an_dup),
        .ctl_reset(c_rst), .ctl_loopback(c_loop), .ctl_power_down(c_pdn),
        .ctl_isolate(c_iso), .ctl_an_enable(c_an), .ctl_an_restart(c_rstrt),
        .ctl_speed(c_spd), .ctl_duplex(c_dup)
    );

    // Pulse counters and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (c_rst)   rst_pulses   <= rst_pulses + 1;
        if (c_rstrt) rstrt_pulses <= rstrt_pulses + 1;
        if (cyc == 195000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // One management bit: master sets data, samples line, then raises mdc.
    task automatic mbit(input logic b, output logic s_oe, output logic s_out);
        @(negedge clk); drv = b;
        repeat (HALF - 1) @(negedge clk);
        s_oe = mdio_oe; s_out = mdio_out;
        mdc = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, output logic [15:0] rd,
                         output int oe_cnt, output logic ta_ok);
        logic [13:0] hdr;
        logic so, sd;
        hdr = {2'b01, op, pa, ra};
        oe_cnt = 0; ta_ok = 1'b1; rd = '0;
        for (int i = 0; i < 32; i++) begin mbit(1'b1, so, sd); if (so) oe_cnt++; end
        for (int i = 13; i >= 0; i--) begin mbit(hdr[i], so, sd); if (so) oe_cnt++; end
        for (int i = 0; i < 18; i++) begin
            logic b;
            b = (op == 2'b01) ? ((i < 2) ? (i == 0) : wd[17 - i]) : 1'b1;
            mbit(b, so, sd);
            if (so) oe_cnt++;
            if (i == 0 && so) ta_ok = 1'b0;
            if (i == 1 && !(so && !sd)) ta_ok = 1'b0;
            if (i >= 2) rd[17 - i] = sd;
        end
    endtask

    task automatic rd_chk(input string req, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] exp);
        logic [15:0] r; int oc; logic ta;
        frame(2'b10, pa, ra, 16'h0, r, oc, ta);
        chk(req, r, exp);
    endtask

    task automatic wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        logic [15:0] r; int oc; logic ta;
        frame(2'b01, pa, ra, d, r, oc, ta);
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [15:0] r; int oc; logic ta;
        logic [4:0] me;
        me = {2'b01, PHY_LOW};
        do_reset();
        @(negedge clk);
        // Reset state of outputs (R8 default negotiation on, R6 speed from an_speed).
        chk("R8 reset an_enable", c_an, 1);
        chk("R6 reset speed", c_spd, 1);
        chk("R7 reset duplex", c_dup, 0);
        chk("R4 no reset pulse", c_rst, 0);
        // R3: read inside hold-off is ignored.
        frame(2'b10, me, 5'd0, 16'h0, r, oc, ta);
        chk("R3 holdoff oe count", oc, 0);
        repeat (HOLD) @(negedge clk);
        // R1 read framing and defaults.
        frame(2'b10, me, 5'd0, 16'h0, r, oc, ta);
        chk("R1 turnaround", ta, 1);
        chk("R1 driven bits", oc, 17);
        chk("R8 ctl default", r, 16'h3000);
        rd_chk("R11 adv default", me, 5'd4, 16'h05E1);
        rd_chk("R12 unmapped reg", me, 5'd2, 16'h0000);
        // R6/R7 manual speed and duplex.
        wr(me, 5'd0, 16'h0100);
        rd_chk("R6 manual ctl", me, 5'd0, 16'h0100);
        chk("R6 speed out", c_spd, 0);
        chk("R7 duplex out", c_dup, 1);
        chk("R8 an out", c_an, 0);
        // R10 loopback at 10 then at 100.
        wr(me, 5'd0, 16'h4100);
        chk("R10 loop at 10M", c_loop, 1);
        wr(me, 5'd0, 16'h6100);
        chk("R10 loop at 100M", c_loop, 0);
        rd_chk("R10 readback", me, 5'd0, 16'h6100);
        // R8 reserved bits.
        wr(me, 5'd0, 16'h00FF);
        rd_chk("R8 reserved zero", me, 5'd0, 16'h0000);
        // R6/R7 read-only under negotiation.
        wr(me, 5'd0, 16'h3000);
        an_spd = 1'b0; an_dup = 1'b1;
        rd_chk("R6 an overrides", me, 5'd0, 16'h1100);
        chk("R7 duplex follows an", c_dup, 1);
        // R5 restart pulse.
        wr(me, 5'd0, 16'h1200);
        chk("R5 restart pulses", rstrt_pulses, 1);
        rd_chk("R5 self clear", me, 5'd0, 16'h1100);
        // R9 power-down.
        wr(me, 5'd0, 16'h5A00);
        chk("R9 pdn out", c_pdn, 1);
        chk("R9 an gated", c_an, 0);
        chk("R9 loop gated", c_loop, 0);
        chk("R9 restart gated", rstrt_pulses, 1);
        rd_chk("R9 mgmt alive", me, 5'd0, 16'h5900);
        // Isolate bit and R11 advertisement write.
        wr(me, 5'd0, 16'h1400);
        chk("R9 isolate out", c_iso, 1);
        wr(me, 5'd4, 16'h0020);
        rd_chk("R11 adv write", me, 5'd4, 16'h0021);
        // R2 sweep of all PHY addresses.
        for (int a = 0; a < 32; a++) begin
            frame(2'b10, 5'(a), 5'd0, 16'h0, r, oc, ta);
            chk("R2 address sweep", oc, (5'(a) == me) ? 17 : 0);
        end
        wr(5'd3, 5'd0, 16'h0000);
        rd_chk("R2 foreign write ignored", me, 5'd0, 16'h1500);
        // R4 soft reset.
        wr(me, 5'd0, 16'h8000);
        chk("R4 reset pulses", rst_pulses, 1);
        rd_chk("R4 ctl defaults", me, 5'd0, 16'h1100);
        rd_chk("R4 adv defaults", me, 5'd4, 16'h05E1);
        // Fibre straps via a second system reset.
        s_phy = 2'b10; s_fx = 1'b1; s_fxdup = 1'b0; s_fxp = 1'b0; s_tpp = 1'b1;
        do_reset();
        repeat (HOLD + 10) @(negedge clk);
        me = {2'b10, PHY_LOW};
        rd_chk("R8 fibre ctl default", me, 5'd0, 16'h2000);
        rd_chk("R11 fibre pause", me, 5'd4, 16'h01E1);
        frame(2'b10, {2'b01, PHY_LOW}, 5'd0, 16'h0, r, oc, ta);
        chk("R2 old address silent", oc, 0);
        wr(me, 5'd0, 16'h0100);
        rd_chk("R6 fibre speed forced", me, 5'd0, 16'h2100);
        chk("R7 fibre duplex out", c_dup, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule